// File: doc/BRIEF.md
# I2C Master Address Phase Sequencer

This block keeps the target-address settings of an I2C master and, for every transfer command, produces the address bytes that open the transfer. A 32-bit configuration word holds four fields: the target address, a 7/10-bit addressing select, a special-command enable and a select bit that picks between general call and START byte. A write to the word lands only while the controller is in a state where changing the target is safe. Live status inputs tell the block whether the controller is enabled, whether it is in master mode, whether a master transfer is running and whether the transmit FIFO is empty.

On an accepted command the block takes a snapshot of the configuration. It then hands one to three bytes to a bit-level bus engine over a valid/ready handshake. It waits for the engine's acknowledge result on every byte except a START byte. A NACK, or a read requested while general-call mode is active, raises a sticky transmit-abort flag. That flag holds back further commands until it is cleared. When the last address byte has been acknowledged, a one-cycle done pulse tells the engine that the address phase is over.

Top module: `i2c_addr_phase`

## Requirements
- R1: After reset the configuration word reads 0x0000_1055: target address 0x55 in bits 9:0, general-call/START select (bit 10) 0, special enable (bit 11) 0, 10-bit select (bit 12) 1.
- R2: Bits 31:13 of the configuration word always read 0, including after a write that sets them.
- R3: A configuration write takes effect on the next clock edge if the controller is disabled, or if it is enabled in master mode with no master transfer active and the transmit FIFO empty. Under any other status the write leaves the word unchanged.
- R4: With special enable 0 and 10-bit select 0, a command sends one byte {address[6:0], R/W}, where R/W is 1 for a read. The general-call/START select bit has no effect in this mode.
- R5: With special enable 0 and 10-bit select 1, a write command sends two bytes: {11110, address[9:8], 0} and then address[7:0].
- R6: A read in 10-bit mode sends those two bytes and then a third byte {11110, address[9:8], 1}. The repeated-start flag is high on the third byte and low on every other byte.
- R7: With special enable 1 and select 0 (general call), a write command sends the single byte 0x00, whatever the address field holds.
- R8: In general-call mode a read command sends no byte, raises the transmit-abort flag on the next edge and produces no done pulse.
- R9: General-call mode applies to every command until software clears special enable. After that, addressing follows the address and 10-bit fields again.
- R10: With special enable 1 and select 1, a command sends the single byte 0x01. The block does not wait for an acknowledge: the done pulse follows the byte handshake directly.
- R11: A NACK on any address byte raises the transmit-abort flag, ends the sequence and sends no further byte.
- R12: The transmit-abort flag stays set until an abort-clear pulse. While it is set, cmd_ready is low and commands are ignored.
- R13: seq_done pulses high for exactly one cycle after each address phase that completes, and never after an aborted one.
- R14: A byte offered with byte_valid keeps its value and flags until byte_ready accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Configuration write strobe |
| reg_wdata | input | 32 | Configuration write data |
| reg_rdata | output | 32 | Configuration word readback |
| ctl_enable | input | 1 | Controller enabled |
| ctl_master | input | 1 | Controller in master mode |
| mst_active | input | 1 | Master transfer in progress |
| txf_empty | input | 1 | Transmit FIFO empty |
| cmd_valid | input | 1 | Transfer command request |
| cmd_read | input | 1 | Command direction, 1 = read |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| byte_valid | output | 1 | Address byte offered to the bus engine |
| byte_data | output | 8 | Address byte value |
| byte_rstart | output | 1 | Precede this byte with a repeated START |
| byte_ready | input | 1 | Bus engine takes the byte |
| ack_valid | input | 1 | Engine reports the acknowledge result of the last byte |
| ack_nack | input | 1 | Reported result was NACK |
| abort_clr | input | 1 | Clears the transmit-abort flag |
| tx_abort | output | 1 | Sticky transmit-abort flag |
| seq_done | output | 1 | Address phase finished |

## Verification
The bench writes the configuration word under each status combination that must block a write. A design that checks only the enable input would then change the target address in the middle of a transfer, and that shows up in the readback. It sets the general-call/START select while special enable is 0, where a design that decodes the select bit on its own sends 0x00 or 0x01 in place of the 7-bit address. It issues a general-call read and then holds cmd_valid with the abort flag set. A design that lets the read through, or lets an abort be bypassed, puts a byte on the handshake that the scoreboard has not queued. It also stalls byte_ready, answers a 10-bit read with a NACK on the second byte, and sends a START byte with no acknowledge. These catch a missing or duplicated third byte, a sequence that carries on after a NACK, and a sequencer that hangs waiting for an acknowledge that never arrives.

// File: rtl/i2c_ap_pkg.sv
package i2c_ap_pkg;

  localparam int TAR_W = 10;
  localparam logic [4:0] HDR10 = 5'b11110;
  localparam logic [7:0] GCALL_BYTE = 8'h00;
  localparam logic [7:0] SBYTE_BYTE = 8'h01;

  typedef struct packed {
    logic             ten_bit;
    logic             special;
    logic             gc_sb_sel;
    logic [TAR_W-1:0] tar;
  } tgt_cfg_t;

  typedef enum logic [1:0] {
    MODE_A7  = 2'd0,
    MODE_A10 = 2'd1,
    MODE_GC  = 2'd2,
    MODE_SB  = 2'd3
  } addr_mode_e;

  // Addressing mode selected by the configuration fields
  function automatic addr_mode_e cfg_mode(input tgt_cfg_t c);
    if (c.special) return c.gc_sb_sel ? MODE_SB : MODE_GC;
    return c.ten_bit ? MODE_A10 : MODE_A7;
  endfunction

  // Index of the final byte of a sequence
  function automatic logic [1:0] seq_last(input addr_mode_e m, input logic rd);
    if (m == MODE_A10) return rd ? 2'd2 : 2'd1;
    return 2'd0;
  endfunction

  // Byte value at position idx of the address sequence
  function automatic logic [7:0] seq_byte(input logic [TAR_W-1:0] tar,
                                          input addr_mode_e m,
                                          input logic rd,
                                          input logic [1:0] idx);
    case (m)
      MODE_A7:  return {tar[6:0], rd};
      MODE_GC:  return GCALL_BYTE;
      MODE_SB:  return SBYTE_BYTE;
      default:  return (idx == 2'd1) ? tar[7:0]
                                     : {HDR10, tar[9:8], (idx == 2'd2)};
    endcase
  endfunction

endpackage

// File: rtl/i2c_ap_cfg_reg.sv
module i2c_ap_cfg_reg
  import i2c_ap_pkg::*;
#(
  parameter int               REG_W   = 32,
  parameter logic [TAR_W-1:0] TAR_RST = 10'h055,
  parameter logic             TEN_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             ctl_enable,
  input  logic             ctl_master,
  input  logic             mst_active,
  input  logic             txf_empty,
  output tgt_cfg_t         cfg,
  output logic [REG_W-1:0] rdata
);
  localparam int CFG_W = $bits(tgt_cfg_t);
  localparam int PAD_W = REG_W - CFG_W;

  logic wr_open;
  logic wr_take;
  logic rsvd_hit;

  assign wr_open  = !ctl_enable || (ctl_master && !mst_active && txf_empty);
  assign wr_take  = wr && wr_open;
  assign rsvd_hit = |wdata[REG_W-1:CFG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.ten_bit   <= TEN_RST;
      cfg.special   <= 1'b0;
      cfg.gc_sb_sel <= 1'b0;
      cfg.tar       <= TAR_RST;
    end else if (wr_take) begin
      cfg <= tgt_cfg_t'(wdata[CFG_W-1:0]);
    end
  end

  assign rdata = {{PAD_W{1'b0}}, cfg};

  assert_wr_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wr_open) |=> $stable(rdata));

  assert_wr_land_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> (rdata[CFG_W-1:0] == $past(wdata[CFG_W-1:0])));

  assert_rsvd_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_take && rsvd_hit) |=> (rdata[REG_W-1:CFG_W] == '0));

endmodule

// File: rtl/i2c_ap_seq.sv
module i2c_ap_seq
  import i2c_ap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  tgt_cfg_t   cfg,
  input  logic       cmd_valid,
  input  logic       cmd_read,
  output logic       cmd_ready,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       byte_rstart,
  input  logic       byte_ready,
  input  logic       ack_valid,
  input  logic       ack_nack,
  input  logic       abort_clr,
  output logic       tx_abort,
  output logic       seq_done
);
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} st_e;

  st_e              state;
  addr_mode_e       snap_mode;
  logic [TAR_W-1:0] snap_tar;
  logic             snap_rd;
  logic [1:0]       idx;

  // Named internal events
  logic cmd_fire, gc_read_evt, byte_fire, sb_fire;
  logic ack_evt, nack_evt, last_ack_evt, abort_set;

  assign cmd_ready    = (state == ST_IDLE) && !tx_abort;
  assign cmd_fire     = cmd_valid && cmd_ready;
  assign gc_read_evt  = cmd_fire && cmd_read && (cfg_mode(cfg) == MODE_GC);
  assign byte_valid   = (state == ST_SEND);
  assign byte_fire    = byte_valid && byte_ready;
  assign sb_fire      = byte_fire && (snap_mode == MODE_SB);
  assign ack_evt      = (state == ST_WAIT) && ack_valid;
  assign nack_evt     = ack_evt && ack_nack;
  assign last_ack_evt = ack_evt && !ack_nack && (idx == seq_last(snap_mode, snap_rd));
  assign abort_set    = gc_read_evt || nack_evt;

  assign byte_data    = seq_byte(snap_tar, snap_mode, snap_rd, idx);
  assign byte_rstart  = (snap_mode == MODE_A10) && (idx == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      snap_mode <= MODE_A7;
      snap_tar  <= '0;
      snap_rd   <= 1'b0;
      idx       <= 2'd0;
      seq_done  <= 1'b0;
    end else begin
      seq_done <= sb_fire || last_ack_evt;
      case (state)
        ST_IDLE: if (cmd_fire) begin
          snap_mode <= cfg_mode(cfg);
          snap_tar  <= cfg.tar;
          snap_rd   <= cmd_read;
          idx       <= 2'd0;
          if (!gc_read_evt) state <= ST_SEND;
        end
        ST_SEND: if (byte_fire) state <= sb_fire ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (ack_evt) begin
          if (nack_evt || last_ack_evt) state <= ST_IDLE;
          else begin
            idx   <= idx + 2'd1;
            state <= ST_SEND;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tx_abort <= 1'b0;
    else if (abort_set) tx_abort <= 1'b1;
    else if (abort_clr) tx_abort <= 1'b0;
  end

  assert_gc_read_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gc_read_evt |=> (tx_abort && !byte_valid));

  assert_nack_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt |=> (tx_abort && !byte_valid));

  assert_abort_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_abort && !abort_clr) |=> tx_abort);

  assert_abort_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_abort && cmd_valid) |=> !byte_valid);

  assert_rstart_hdr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_rstart) |-> ((byte_data[7:3] == HDR10) && byte_data[0]));

  assert_sb_noack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sb_fire |=> (seq_done && !byte_valid));

  assert_done_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  assert_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready) |=>
      (byte_valid && $stable(byte_data) && $stable(byte_rstart)));

endmodule

// File: rtl/i2c_addr_phase.sv
module i2c_addr_phase
  import i2c_ap_pkg::*;
#(
  parameter int               REG_W   = 32,
  parameter logic [TAR_W-1:0] TAR_RST = 10'h055,
  parameter logic             TEN_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ctl_enable,
  input  logic             ctl_master,
  input  logic             mst_active,
  input  logic             txf_empty,
  input  logic             cmd_valid,
  input  logic             cmd_read,
  output logic             cmd_ready,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic             byte_rstart,
  input  logic             byte_ready,
  input  logic             ack_valid,
  input  logic             ack_nack,
  input  logic             abort_clr,
  output logic             tx_abort,
  output logic             seq_done
);
  tgt_cfg_t cfg;

  i2c_ap_cfg_reg #(
    .REG_W  (REG_W),
    .TAR_RST(TAR_RST),
    .TEN_RST(TEN_RST)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .wdata     (reg_wdata),
    .ctl_enable(ctl_enable),
    .ctl_master(ctl_master),
    .mst_active(mst_active),
    .txf_empty (txf_empty),
    .cfg       (cfg),
    .rdata     (reg_rdata)
  );

  i2c_ap_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .cmd_valid  (cmd_valid),
    .cmd_read   (cmd_read),
    .cmd_ready  (cmd_ready),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_rstart(byte_rstart),
    .byte_ready (byte_ready),
    .ack_valid  (ack_valid),
    .ack_nack   (ack_nack),
    .abort_clr  (abort_clr),
    .tx_abort   (tx_abort),
    .seq_done   (seq_done)
  );

endmodule

// File: tb/i2c_addr_phase_tb.sv
`timescale 1ns/1ps
module i2c_addr_phase_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ctl_enable = 1'b0, ctl_master = 1'b1, mst_active = 1'b0, txf_empty = 1'b1;
  logic        cmd_valid = 1'b0, cmd_read = 1'b0, cmd_ready;
  logic        byte_valid, byte_rstart;
  logic [7:0]  byte_data;
  logic        byte_ready = 1'b0, ack_valid = 1'b0, ack_nack = 1'b0, abort_clr = 1'b0;
  logic        tx_abort, seq_done;

  always #4 clk = ~clk;

  i2c_addr_phase u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ctl_enable(ctl_enable), .ctl_master(ctl_master), .mst_active(mst_active),
    .txf_empty(txf_empty), .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_ready(cmd_ready),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_rstart(byte_rstart),
    .byte_ready(byte_ready), .ack_valid(ack_valid), .ack_nack(ack_nack),
    .abort_clr(abort_clr), .tx_abort(tx_abort), .seq_done(seq_done)
  );

  int n_chk = 0;
  int n_err = 0;
  int done_cnt = 0;

  // Scoreboard item: {needs_ack, reply_nack, rstart, data[7:0]}
  logic [10:0] exp_q[$];
  string       tag_q[$];

  logic [7:0] rdy_pat = 8'b1101_0111;
  logic       ack_pend = 1'b0;
  logic       pend_nack = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] b7(input int tar, input bit rd);
    return 8'((tar % 128) * 2 + int'(rd));
  endfunction

  function automatic logic [7:0] hdr10(input int tar, input bit rd);
    return 8'(240 + ((tar / 256) % 4) * 2 + int'(rd));
  endfunction

  task automatic push(input bit ack, input bit nack, input bit rs, input logic [7:0] d,
                      input string tag);
    exp_q.push_back({ack, nack, rs, d});
    tag_q.push_back(tag);
  endtask

  // Bus engine model and monitor
  always @(negedge clk) begin
    ack_valid = 1'b0;
    ack_nack  = 1'b0;
    if (seq_done) done_cnt++;
    if (ack_pend) begin
      ack_valid = 1'b1;
      ack_nack  = pend_nack;
      ack_pend  = 1'b0;
    end
    byte_ready = rdy_pat[0];
    rdy_pat    = {rdy_pat[0], rdy_pat[7:1]};
    if (byte_valid && byte_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12/R11 unexpected byte", byte_data, 0);
        ack_pend  = 1'b1;
        pend_nack = 1'b0;
      end else begin
        logic [10:0] it;
        string tg;
        it = exp_q.pop_front();
        tg = tag_q.pop_front();
        check({byte_rstart, byte_data} == it[8:0], tg, {byte_rstart, byte_data}, it[8:0]);
        ack_pend  = it[10];
        pend_nack = it[9];
      end
    end
  end

  task automatic wr_reg(input logic [31:0] d, input bit en, input bit ms, input bit act,
                        input bit emp);
    ctl_enable = en; ctl_master = ms; mst_active = act; txf_empty = emp;
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    ctl_enable = 1'b1; ctl_master = 1'b1; mst_active = 1'b0; txf_empty = 1'b1;
  endtask

  task automatic run_cmd(input bit rd);
    for (int i = 0; i < 50; i++) begin
      if (cmd_ready) break;
      @(negedge clk);
    end
    cmd_valid = 1'b1; cmd_read = rd;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic finish_cmd(input string req, input int done0, input int dinc, input bit abt);
    check(exp_q.size() == 0, {req, " bytes left"}, exp_q.size(), 0);
    check(done_cnt - done0 == dinc, {req, " R13 done count"}, done_cnt - done0, dinc);
    check(tx_abort == abt, {req, " abort flag"}, tx_abort, abt);
  endtask

  task automatic clr_abort();
    abort_clr = 1'b1;
    @(negedge clk);
    abort_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int d0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reg_rdata == 32'h0000_1055, "R1 reset word", reg_rdata, 32'h1055);
    check(cmd_ready && !tx_abort && !byte_valid && !seq_done, "R1 reset outputs",
          {cmd_ready, tx_abort, byte_valid, seq_done}, 4'b1000);

    // R1 reset config drives 10-bit write to 0x55
    d0 = done_cnt;
    push(1, 0, 0, hdr10(32'h55, 0), "R1 R5 hdr");
    push(1, 0, 0, 8'h55, "R1 R5 low");
    run_cmd(0);
    finish_cmd("R5 reset", d0, 1, 0);

    // R3 blocked writes
    wr_reg(32'h0000_0123, 1, 1, 1, 1);
    check(reg_rdata == 32'h1055, "R3 blocked active", reg_rdata, 32'h1055);
    wr_reg(32'h0000_0123, 1, 0, 0, 1);
    check(reg_rdata == 32'h1055, "R3 blocked slave mode", reg_rdata, 32'h1055);
    wr_reg(32'h0000_0123, 1, 1, 0, 0);
    check(reg_rdata == 32'h1055, "R3 blocked fifo", reg_rdata, 32'h1055);

    // R2 R3 disabled write, reserved bits set; 7-bit, select bit without special
    wr_reg(32'hFFFF_E000 | 32'h0400 | 32'h2A5, 0, 0, 1, 0);
    check(reg_rdata == 32'h0000_06A5, "R2 R3 disabled write", reg_rdata, 32'h6A5);

    d0 = done_cnt;
    push(1, 0, 0, b7(32'h2A5, 0), "R4 7-bit write");
    run_cmd(0);
    finish_cmd("R4 wr", d0, 1, 0);
    d0 = done_cnt;
    push(1, 0, 0, b7(32'h2A5, 1), "R4 7-bit read");
    run_cmd(1);
    finish_cmd("R4 rd", d0, 1, 0);

    // R3 enabled-idle write, 10-bit
    wr_reg(32'h0000_1000 | 32'h2A5, 1, 1, 0, 1);
    check(reg_rdata == 32'h0000_12A5, "R3 enabled idle write", reg_rdata, 32'h12A5);
    d0 = done_cnt;
    push(1, 0, 0, hdr10(32'h2A5, 0), "R5 hdr");
    push(1, 0, 0, 8'hA5, "R5 low");
    run_cmd(0);
    finish_cmd("R5 wr", d0, 1, 0);
    d0 = done_cnt;
    push(1, 0, 0, hdr10(32'h2A5, 0), "R6 hdr");
    push(1, 0, 0, 8'hA5, "R6 low");
    push(1, 0, 1, hdr10(32'h2A5, 1), "R6 rstart hdr");
    run_cmd(1);
    finish_cmd("R6 rd", d0, 1, 0);

    // R7 R9 general call persists
    wr_reg(32'h0000_0800 | 32'h3FF, 1, 1, 0, 1);
    d0 = done_cnt;
    push(1, 0, 0, 8'h00, "R7 gcall");
    run_cmd(0);
    finish_cmd("R7", d0, 1, 0);
    d0 = done_cnt;
    push(1, 0, 0, 8'h00, "R9 gcall again");
    run_cmd(0);
    finish_cmd("R9", d0, 1, 0);
    // R8 read in general call
    d0 = done_cnt;
    run_cmd(1);
    finish_cmd("R8", d0, 0, 1);
    check(!cmd_ready, "R12 ready low in abort", cmd_ready, 0);
    // R12 commands ignored while aborted
    cmd_valid = 1'b1; cmd_read = 1'b0;
    repeat (4) @(negedge clk);
    cmd_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(tx_abort && !cmd_ready, "R12 sticky", {tx_abort, cmd_ready}, 2'b10);
    clr_abort();
    check(!tx_abort && cmd_ready, "R12 cleared", {tx_abort, cmd_ready}, 2'b01);

    // R9 leaving general call
    wr_reg(32'h0000_0012, 1, 1, 0, 1);
    d0 = done_cnt;
    push(1, 0, 0, b7(32'h12, 0), "R9 back to 7-bit");
    run_cmd(0);
    finish_cmd("R9 exit", d0, 1, 0);

    // R10 START byte, no acknowledge
    wr_reg(32'h0000_0C00 | 32'h012, 1, 1, 0, 1);
    d0 = done_cnt;
    push(0, 0, 0, 8'h01, "R10 start byte");
    run_cmd(1);
    finish_cmd("R10", d0, 1, 0);

    // R11 NACK on second byte of 10-bit read
    wr_reg(32'h0000_1000 | 32'h155, 1, 1, 0, 1);
    d0 = done_cnt;
    push(1, 0, 0, hdr10(32'h155, 0), "R11 hdr");
    push(1, 1, 0, 8'h55, "R11 nacked low");
    run_cmd(1);
    finish_cmd("R11", d0, 0, 1);
    clr_abort();

    // recovery after abort
    d0 = done_cnt;
    push(1, 0, 0, hdr10(32'h155, 0), "R12 after clear hdr");
    push(1, 0, 0, 8'h55, "R12 after clear low");
    run_cmd(0);
    finish_cmd("R12 recover", d0, 1, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule